// File: doc/BRIEF.md
# Iterative AES-128 Block Encryption Sequencer

This block encrypts one 128-bit block under a 128-bit cipher key with the AES-128 cipher. A single round datapath is reused for every round. A nine-state controller steps it through the initial key addition, nine full rounds and a last round that leaves out the column mixing. The byte substitution tables are registered, like a synchronous memory. The key schedule is a two-stage pipeline: a registered word substitution followed by a registered next-key word. The controller therefore adds fixed wait states so that each operand has settled before it is used.

To use the block, drive the plaintext and the key, then pulse `load` for one or more cycles. Hold both inputs steady until `done` rises. The ciphertext then appears on `cipherText` and stays there, with `done` held high, until the next `load`. A `load` in the middle of a run drops the block in progress and starts again from the present inputs.

Top module: `aes_iter_enc`

## Requirements
- R1: When `done` is high, `cipherText` equals the AES-128 encryption of the `plainText` and `cipherKey` that were held from the load until `done`. The 128-bit values are big-endian, and state byte i sits at bits [127-8i -: 8], column-major.
- R2: `done` rises exactly 40 rising clock edges after the last edge that samples `load` high. `cipherText` is valid from that same cycle.
- R3: An edge that samples `load` high sends the controller to its start state and clears `done` by the next cycle. A load in the middle of a run drops that run, and only the new block's result is ever flagged.
- R4: Once set, `done` stays high and `cipherText` stays constant until the next load. Changes on `plainText` and `cipherKey` during that time have no effect.
- R5: After reset, `done` is 0 and `cipherText` is all zeros. The controller waits in its idle (final) state, and no encryption starts until `load` is sampled high.
- R6: The controller uses a 4-bit state register with states S0..S8. The fixed order is S0, S1, S2, S3, S4. S4 returns to S1 while the round counter is below 9 and moves to S5 when the counter is 9. After that the order is S5, S6, S7, S8, and S8 holds.
- R7: The round constant is 01 for round 1 and doubles in GF(2^8) (polynomial 11B) each round, which gives 1B for round 9 and 36 for round 10. It is applied to the most significant byte of the key-schedule word.
- R8: The last round skips the column mixing. The shifted-row result is held in S5, the round-10 key is saved in S6, and both are combined in S7 to form the ciphertext.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rstN | input | 1 | Asynchronous active-low reset |
| load | input | 1 | Start (or restart) an encryption |
| plainText | input | 128 | Block to encrypt, held until done |
| cipherKey | input | 128 | Cipher key, held until done |
| cipherText | output | 128 | Encrypted block, valid while done is high |
| done | output | 1 | Sticky completion flag, cleared by load |

## Verification
Most internal faults in this block cannot be seen until the end of a run. A wrong S-box entry, a wrong byte position, a missed wait state or a wrong round constant spreads through every later round. It shows up as a completely wrong `cipherText` when `done` rises, 40 cycles after the load. A controller that stalls or skips states shows up at the ports as a change in that 40-cycle latency, or as `done` never rising. Known-answer vectors with unlike keys and plaintexts, an exact latency count, an aborted run and input changes after completion cover these cases.

// File: rtl/aes_iter_pkg.sv
package aes_iter_pkg;

  typedef enum logic [3:0] {
    S0 = 4'd0, S1 = 4'd1, S2 = 4'd2, S3 = 4'd3, S4 = 4'd4,
    S5 = 4'd5, S6 = 4'd6, S7 = 4'd7, S8 = 4'd8
  } ctrlState_e;

  typedef enum logic [1:0] {DSEL_CUR, DSEL_PT, DSEL_MIX, DSEL_HOLD} dataSel_e;
  typedef enum logic [1:0] {KSEL_CUR, KSEL_INIT, KSEL_FINAL} keySel_e;

  // strobes from the controller to the round datapath
  typedef struct packed {
    dataSel_e   dataSel;
    keySel_e    keySel;
    logic       capState;
    logic       capKey;
    logic       capHold;
    logic       capFinalKey;
    logic [7:0] rcon;
  } pathCtl_t;

  function automatic logic [7:0] xtime(input logic [7:0] a);
    return {a[6:0], 1'b0} ^ (a[7] ? 8'h1B : 8'h00);
  endfunction

  function automatic logic [7:0] gfMul(input logic [7:0] a, input logic [7:0] b);
    logic [7:0] p, x;
    p = 8'h00;
    x = a;
    for (int i = 0; i < 8; i++) begin
      if (b[i]) p = p ^ x;
      x = xtime(x);
    end
    return p;
  endfunction

  function automatic logic [7:0] rotl8(input logic [7:0] x, input int n);
    return (x << n) | (x >> (8 - n));
  endfunction

  // S-box computed as multiplicative inverse (x^254) followed by the affine map
  function automatic logic [7:0] sboxByte(input logic [7:0] x);
    logic [7:0] r, b;
    r = 8'h01;
    b = x;
    for (int i = 0; i < 8; i++) begin
      if (i != 0) r = gfMul(r, b);   // 254 = all exponent bits except bit 0
      b = gfMul(b, b);
    end
    return r ^ rotl8(r, 1) ^ rotl8(r, 2) ^ rotl8(r, 3) ^ rotl8(r, 4) ^ 8'h63;
  endfunction

  function automatic logic [127:0] subBytes128(input logic [127:0] s);
    logic [127:0] o;
    for (int i = 0; i < 16; i++) o[8*i +: 8] = sboxByte(s[8*i +: 8]);
    return o;
  endfunction

  function automatic logic [31:0] subWord32(input logic [31:0] w);
    logic [31:0] o;
    for (int i = 0; i < 4; i++) o[8*i +: 8] = sboxByte(w[8*i +: 8]);
    return o;
  endfunction

  // byte i = row + 4*col lives at [127-8i -: 8]
  function automatic logic [127:0] shiftRows128(input logic [127:0] s);
    logic [127:0] o;
    for (int c = 0; c < 4; c++)
      for (int r = 0; r < 4; r++)
        o[127 - 8*(r + 4*c) -: 8] = s[127 - 8*(r + 4*((c + r) % 4)) -: 8];
    return o;
  endfunction

  function automatic logic [31:0] mixCol32(input logic [31:0] col);
    logic [7:0] a0, a1, a2, a3;
    {a0, a1, a2, a3} = col;
    return {xtime(a0) ^ gfMul(a1, 8'h03) ^ a2 ^ a3,
            a0 ^ xtime(a1) ^ gfMul(a2, 8'h03) ^ a3,
            a0 ^ a1 ^ xtime(a2) ^ gfMul(a3, 8'h03),
            gfMul(a0, 8'h03) ^ a1 ^ a2 ^ xtime(a3)};
  endfunction

  function automatic logic [127:0] mixColumns128(input logic [127:0] s);
    logic [127:0] o;
    for (int c = 0; c < 4; c++) o[127 - 32*c -: 32] = mixCol32(s[127 - 32*c -: 32]);
    return o;
  endfunction

  function automatic logic [7:0] rconFor(input int idx);
    logic [7:0] r;
    r = 8'h01;
    for (int i = 1; i < 16; i++) if (i < idx) r = xtime(r);
    return r;
  endfunction

endpackage

// File: rtl/aes_iter_ctrl.sv
module aes_iter_ctrl
  import aes_iter_pkg::*;
#(
  parameter int ROUNDS = 10
) (
  input  logic     clk,
  input  logic     rstN,
  input  logic     load,
  output pathCtl_t ctl,
  output logic     done
);

  localparam int LAST_FULL = ROUNDS - 1;
  localparam int RW        = $clog2(ROUNDS + 1);

  ctrlState_e ctrlState, ctrlNext;
  logic [RW-1:0] roundCnt;
  logic finalPhase;

  always_comb begin
    ctrlNext = ctrlState;
    unique case (ctrlState)
      S0: ctrlNext = S1;
      S1: ctrlNext = S2;
      S2: ctrlNext = S3;
      S3: ctrlNext = S4;
      S4: ctrlNext = (roundCnt < RW'(LAST_FULL)) ? S1 : S5;
      S5: ctrlNext = S6;
      S6: ctrlNext = S7;
      S7: ctrlNext = S8;
      default: ctrlNext = S8;
    endcase
    if (load) ctrlNext = S0;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      ctrlState <= S8;
      roundCnt  <= '0;
      done      <= 1'b0;
    end else begin
      ctrlState <= ctrlNext;
      if (load) begin
        roundCnt <= '0;
        done     <= 1'b0;
      end else begin
        if (ctrlState == S0) roundCnt <= RW'(1);
        if (ctrlState == S4 && roundCnt < RW'(LAST_FULL)) roundCnt <= roundCnt + 1'b1;
        if (ctrlState == S7) done <= 1'b1;
      end
    end
  end

  assign finalPhase = (ctrlState == S5) || (ctrlState == S6) || (ctrlState == S7);

  always_comb begin
    ctl             = '0;
    ctl.dataSel     = DSEL_CUR;
    ctl.keySel      = KSEL_CUR;
    ctl.rcon        = rconFor(finalPhase ? ROUNDS : int'(roundCnt));
    unique case (ctrlState)
      S0: begin
        ctl.dataSel  = DSEL_PT;
        ctl.keySel   = KSEL_INIT;
        ctl.capState = 1'b1;
        ctl.capKey   = 1'b1;
      end
      S4: begin
        ctl.dataSel  = DSEL_MIX;
        ctl.capState = 1'b1;
        ctl.capKey   = 1'b1;
      end
      S5: ctl.capHold     = 1'b1;
      S6: ctl.capFinalKey = 1'b1;
      S7: begin
        ctl.dataSel  = DSEL_HOLD;
        ctl.keySel   = KSEL_FINAL;
        ctl.capState = 1'b1;
      end
      default: ;
    endcase
  end

  // R3: load restarts and clears the flag
  a_r3_load_restart: assert property (@(posedge clk) disable iff (!rstN)
    load |=> (ctrlState == S0 && !done));
  // R6: fixed order through the wait states
  a_r6_s1_to_s2: assert property (@(posedge clk) disable iff (!rstN)
    (ctrlState == S1 && !load) |=> ctrlState == S2);
  a_r6_s2_to_s3: assert property (@(posedge clk) disable iff (!rstN)
    (ctrlState == S2 && !load) |=> ctrlState == S3);
  a_r6_s3_to_s4: assert property (@(posedge clk) disable iff (!rstN)
    (ctrlState == S3 && !load) |=> ctrlState == S4);
  a_r6_idle_holds: assert property (@(posedge clk) disable iff (!rstN)
    (ctrlState == S8 && !load) |=> ctrlState == S8);
  a_r6_round_bound: assert property (@(posedge clk) disable iff (!rstN)
    roundCnt <= RW'(LAST_FULL));
  a_r6_leave_on_last: assert property (@(posedge clk) disable iff (!rstN)
    (ctrlState == S4 && !load && roundCnt == RW'(LAST_FULL)) |=> ctrlState == S5);
  // R4: completion flag is sticky
  a_r4_done_sticky: assert property (@(posedge clk) disable iff (!rstN)
    (done && !load) |=> done);
  // R2: the flag only rises out of the final addition state
  a_r2_done_from_s7: assert property (@(posedge clk) disable iff (!rstN)
    $rose(done) |-> $past(ctrlState) == S7);

endmodule

// File: rtl/aes_iter_path.sv
module aes_iter_path
  import aes_iter_pkg::*;
(
  input  logic           clk,
  input  logic           rstN,
  input  pathCtl_t       ctl,
  input  logic [127:0]   plainText,
  input  logic [127:0]   cipherKey,
  output logic [127:0]   stateOut
);

  logic [127:0] stateReg, keyReg, sbReg, keyNextReg, holdReg, finalKeyReg;
  logic [31:0]  swReg;
  logic [127:0] arkData, arkKey, arkOut, stateNext, keyLoadVal, keyNext;
  logic [127:0] shiftOut, mixOut, expandOut;
  logic [31:0]  kw0, kw1, kw2, kw3, tmpWord, nw0, nw1, nw2, nw3;

  assign shiftOut = shiftRows128(sbReg);
  assign mixOut   = mixColumns128(shiftOut);

  always_comb begin
    unique case (ctl.dataSel)
      DSEL_PT:   arkData = plainText;
      DSEL_MIX:  arkData = mixOut;
      DSEL_HOLD: arkData = holdReg;
      default:   arkData = stateReg;
    endcase
    unique case (ctl.keySel)
      KSEL_INIT:  arkKey = cipherKey;
      KSEL_FINAL: arkKey = finalKeyReg;
      default:    arkKey = keyNextReg;
    endcase
  end

  assign arkOut     = arkData ^ arkKey;
  assign stateNext  = ctl.capState ? arkOut : stateReg;
  assign keyLoadVal = (ctl.keySel == KSEL_INIT) ? cipherKey : keyNextReg;
  assign keyNext    = ctl.capKey ? keyLoadVal : keyReg;

  // one key-schedule step from the registered substituted word
  assign {kw0, kw1, kw2, kw3} = keyReg;
  assign tmpWord   = swReg ^ {ctl.rcon, 24'h000000};
  assign nw0       = kw0 ^ tmpWord;
  assign nw1       = kw1 ^ nw0;
  assign nw2       = kw2 ^ nw1;
  assign nw3       = kw3 ^ nw2;
  assign expandOut = {nw0, nw1, nw2, nw3};

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      stateReg    <= '0;
      keyReg      <= '0;
      sbReg       <= '0;
      swReg       <= '0;
      keyNextReg  <= '0;
      holdReg     <= '0;
      finalKeyReg <= '0;
    end else begin
      stateReg   <= stateNext;
      keyReg     <= keyNext;
      // registered S-box lookups track the value the registers are taking
      sbReg      <= subBytes128(stateNext);
      swReg      <= subWord32({keyNext[23:0], keyNext[31:24]});
      keyNextReg <= expandOut;
      if (ctl.capHold)     holdReg     <= shiftOut;
      if (ctl.capFinalKey) finalKeyReg <= keyNextReg;
    end
  end

  assign stateOut = stateReg;

  // R8: the held shifted-row value is only ever paired with the saved last key
  a_r8_final_pair: assert property (@(posedge clk) disable iff (!rstN)
    (ctl.dataSel == DSEL_HOLD) |-> (ctl.keySel == KSEL_FINAL && ctl.capState));
  // R8: the last key is saved one cycle after the held value
  a_r8_key_after_hold: assert property (@(posedge clk) disable iff (!rstN)
    ctl.capHold |=> ctl.capFinalKey);
  // R4: the state register only moves on a capture strobe
  a_r4_state_frozen: assert property (@(posedge clk) disable iff (!rstN)
    !$past(ctl.capState) |-> $stable(stateReg));

endmodule

// File: rtl/aes_iter_enc.sv
module aes_iter_enc
  import aes_iter_pkg::*;
#(
  parameter int ROUNDS = 10
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic         load,
  input  logic [127:0] plainText,
  input  logic [127:0] cipherKey,
  output logic [127:0] cipherText,
  output logic         done
);

  pathCtl_t ctl;

  aes_iter_ctrl #(.ROUNDS(ROUNDS)) uCtrl (
    .clk  (clk),
    .rstN (rstN),
    .load (load),
    .ctl  (ctl),
    .done (done)
  );

  aes_iter_path uPath (
    .clk       (clk),
    .rstN      (rstN),
    .ctl       (ctl),
    .plainText (plainText),
    .cipherKey (cipherKey),
    .stateOut  (cipherText)
  );

endmodule

// File: tb/tb_aes_iter_enc.sv
module tb_aes_iter_enc;

  logic         clk = 1'b0;
  logic         rstN = 1'b0;
  logic         load = 1'b0;
  logic [127:0] plainText = '0;
  logic [127:0] cipherKey = '0;
  logic [127:0] cipherText;
  logic         done;

  int checks = 0;
  int fails  = 0;
  bit finished = 1'b0;
  logic [127:0] expQ[$];
  logic prevDone = 1'b0;

  always #10 clk = ~clk;

  aes_iter_enc dut (
    .clk(clk), .rstN(rstN), .load(load),
    .plainText(plainText), .cipherKey(cipherKey),
    .cipherText(cipherText), .done(done)
  );

  task automatic check(input bit ok, input string tag, input logic [127:0] act,
                       input logic [127:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // monitor: on each rising done, pop the expected ciphertext and compare (R1 R7 R8)
  always @(negedge clk) begin
    if (rstN && done && !prevDone) begin
      if (expQ.size() == 0) check(1'b0, "R3 unexpected done", cipherText, '0);
      else begin
        logic [127:0] e;
        e = expQ.pop_front();
        check(cipherText == e, "R1 R7 R8 ciphertext", cipherText, e);
      end
    end
    prevDone = done;
  end

  // driver: start one block, push its expectation, and measure latency (R2 R6)
  task automatic runBlock(input logic [127:0] pt, input logic [127:0] key,
                          input logic [127:0] exp, input int loadLen);
    int k;
    @(negedge clk);
    plainText = pt;
    cipherKey = key;
    load = 1'b1;
    expQ.push_back(exp);
    for (int i = 1; i < loadLen; i++) @(negedge clk);
    @(negedge clk);
    load = 1'b0;
    check(done == 1'b0, "R3 done cleared after load", {127'd0, done}, '0);
    k = 1;
    while (!done && k < 200) begin
      @(negedge clk);
      k++;
    end
    check(k == 41, "R2 R6 latency", 128'(k - 1), 128'd40);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R5: reset state
    check(done == 1'b0, "R5 done after reset", {127'd0, done}, '0);
    check(cipherText == '0, "R5 ciphertext after reset", cipherText, '0);
    rstN = 1'b1;
    repeat (10) @(negedge clk);
    check(done == 1'b0, "R5 idle without load", {127'd0, done}, '0);

    runBlock(128'h00112233445566778899aabbccddeeff, 128'h000102030405060708090a0b0c0d0e0f,
             128'h69c4e0d86a7b0430d8cdb78070b4c55a, 1);
    runBlock(128'h3243f6a8885a308d313198a2e0370734, 128'h2b7e151628aed2a6abf7158809cf4f3c,
             128'h3925841d02dc09fbdc118597196a0b32, 1);

    // R4: sticky result, inputs ignored after completion
    for (int i = 0; i < 20; i++) begin
      plainText = {$urandom, $urandom, $urandom, $urandom};
      cipherKey = {$urandom, $urandom, $urandom, $urandom};
      @(negedge clk);
      if (i % 5 == 4) begin
        check(done == 1'b1, "R4 done sticky", {127'd0, done}, 128'd1);
        check(cipherText == 128'h3925841d02dc09fbdc118597196a0b32, "R4 result held",
              cipherText, 128'h3925841d02dc09fbdc118597196a0b32);
      end
    end

    // R3: abort a run midway, only the new block completes
    @(negedge clk);
    plainText = 128'hffeeddccbbaa99887766554433221100;
    cipherKey = 128'h0f0e0d0c0b0a09080706050403020100;
    load = 1'b1;
    @(negedge clk);
    load = 1'b0;
    repeat (15) @(negedge clk);
    check(done == 1'b0, "R3 mid-run not done", {127'd0, done}, '0);
    runBlock(128'h6bc1bee22e409f96e93d7e117393172a, 128'h2b7e151628aed2a6abf7158809cf4f3c,
             128'h3ad77bb40d7a3660a89ecaf32466ef97, 1);

    // R2: long load pulse, latency counted from the last load edge
    runBlock(128'h0, 128'h0, 128'h66e94bd4ef8a2c3b884cfa59ca342b2e, 3);

    repeat (5) @(negedge clk);
    check(expQ.size() == 0, "R3 all results seen", 128'(expQ.size()), '0);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    finished = 1'b1;
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      checks++;
      fails++;
      $display("FAIL watchdog R2 actual=%h expected=%h", 128'd0, 128'd1);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end

endmodule